// File: doc/BRIEF.md
# Mechanism Pulse Command Sequencer

This block moves a small set of two-position mechanisms, by default two slit assemblies and a pop-up mirror. A move request names a mechanism, a direction (toward the "in" or the "out" position) and a drive path (primary or secondary). The block answers each accepted request with one fixed-length drive pulse. The pulse goes high on exactly one output, and a 1 on that output runs the motor. Only one pulse may be active anywhere in the block at any moment. A request that arrives while a move is under way is turned away. A request that names an impossible target is also turned away.

When the pulse ends, the block reads the active-low position telltale for the requested position. It does this one cycle later, through a two-flop synchronizer. It then records the outcome in a result register: success, failure, or unverified when that position has no telltale. On the mirror, "in" is the backup detector position and "out" is the primary detector position. Only the out position carries a telltale. The two active-low cover telltales pass through the same synchronizer and come out as active-high status. The pulse length is a cycle-count parameter. At the default it gives 500 ms at 50 MHz.

Top module: `mech_pulse_seq`

## Requirements
- R1: The clock edge that samples an accepted request (`req_valid`=1 while idle and legal) raises exactly the selected output. The output is chosen by `req_mech` (0 and 1 are slits, 2 is the mirror), `req_dir` (1=in, 0=out) and `req_path` (0=primary, 1=secondary). The output stays high for exactly PULSE_CYCLES clock cycles and then returns to 0.
- R2: No more than one of the drive output bits across `drv_pri_in`, `drv_pri_out`, `drv_sec_in` and `drv_sec_out` is ever 1 at the same time.
- R3: While `busy` is 1, a request is refused. `req_refused` is 1 for the cycle after it, and no drive output and no result changes because of it.
- R4: A request is refused the same way, and `busy` stays 0, in two cases: the `req_mech` value is N_MECH or above, or it asks for the secondary path of a mechanism whose SEC_PRESENT bit is 0. With the default SEC_PRESENT=3'b011 the mirror has no secondary path.
- R5: Every telltale input reaches the block's logic through two flops. A change on an input is seen by the logic two clock edges after it is applied.
- R6: On the clock edge after the pulse ends, `done` is 1 for one cycle and `busy` falls. `res_code` becomes 01 (success) if the synchronized telltale for the requested position reads 0.
- R7: Under the same conditions, `res_code` becomes 10 (failure) if that telltale reads 1.
- R8: If the requested position has no telltale, `res_code` becomes 11 (unverified) whatever the inputs are. Telltale presence is set by IN_TT_PRESENT and OUT_TT_PRESENT; by default the mirror's in position has none. `res_code` holds its value until the next result.
- R9: After reset, all drive outputs, `busy`, `done`, `req_refused` and `res_code` (00) are 0.
- R10: `cover_closed` and `cover_open` are the inverted, synchronized values of the active-low inputs `cover_closed_n` and `cover_open_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Move request strobe, sampled each edge |
| req_mech | input | MW | Mechanism index |
| req_dir | input | 1 | 1 = move in, 0 = move out |
| req_path | input | 1 | 0 = primary drive, 1 = secondary drive |
| tt_in_n | input | N_MECH | Active-low "at in position" telltales |
| tt_out_n | input | N_MECH | Active-low "at out position" telltales |
| cover_closed_n | input | 1 | Active-low cover closed telltale |
| cover_open_n | input | 1 | Active-low cover full-open telltale |
| busy | output | 1 | A move is in its pulse or check cycle |
| req_refused | output | 1 | One-cycle flag: last sampled request refused |
| drv_pri_in | output | N_MECH | Primary-path in drive pulses |
| drv_pri_out | output | N_MECH | Primary-path out drive pulses |
| drv_sec_in | output | N_MECH | Secondary-path in drive pulses |
| drv_sec_out | output | N_MECH | Secondary-path out drive pulses |
| done | output | 1 | One-cycle flag: new result in res_code |
| res_code | output | 2 | 00 none, 01 success, 10 failure, 11 unverified |
| cover_closed | output | 1 | Cover closed status, active high |
| cover_open | output | 1 | Cover full-open status, active high |

## Verification
The hardest case to reach is a telltale that changes in the last cycles of a pulse. Because of the two-flop delay, the check must see the old value if the change lands one edge before the check and the new value if it lands two edges before. The stimulus therefore times telltale flips against the pulse end counted from the accepting edge, in both placements. It also issues requests during the pulse and during the single check cycle, so that refusal is exercised in both busy states. After those cases it sweeps every mechanism, direction and path against changing telltale patterns.

// File: rtl/mps_pkg.sv
// Shared types for the mechanism pulse sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mps_pkg;

    // Sequencer phase.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CHECK = 2'd2
    } seq_state_t;

    // Outcome of the last completed move.
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_OK    = 2'd1,
        RES_FAIL  = 2'd2,
        RES_UNVER = 2'd3
    } move_res_t;

endpackage

// File: rtl/mps_sync.sv
// Two-flop synchronizer for a bundle of asynchronous level inputs.
// Assumes: each bit is independent; no bus coherence is implied.
// Reset value is all ones (active-low "not at position").
module mps_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            sync_o <= '1;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end

endmodule

// File: rtl/mps_pulse_timer.sv
// Fixed-length pulse timer: after start, running is high for exactly
// LEN clock cycles; expire marks the final cycle.
// Assumes: start is only asserted while running is low.
module mps_pulse_timer #(
    parameter int LEN = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic expire
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] remain;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            running <= 1'b1;
            remain  <= CW'(LEN - 1);
        end else if (running) begin
            if (remain == '0) running <= 1'b0;
            else              remain  <= remain - 1'b1;
        end
    end

    // Last cycle of the pulse.
    always_comb expire = running && (remain == '0);

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !start); // R3

endmodule

// File: rtl/mech_pulse_seq.sv
// Mechanism pulse command sequencer.
// Accepts one move request at a time, drives a single fixed-length pulse
// on the selected in/out output of the primary or secondary path, then
// checks the synchronized active-low telltale and records the outcome.
// Assumes: telltales are asynchronous levels; mechanism index 0..N_MECH-1.
module mech_pulse_seq
    import mps_pkg::*;
#(
    parameter int               N_MECH         = 3,
    parameter int               PULSE_CYCLES   = 25_000_000,
    parameter logic [N_MECH-1:0] SEC_PRESENT    = 3'b011,
    parameter logic [N_MECH-1:0] IN_TT_PRESENT  = 3'b011,
    parameter logic [N_MECH-1:0] OUT_TT_PRESENT = 3'b111,
    localparam int              MW             = (N_MECH > 1) ? $clog2(N_MECH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MW-1:0]     req_mech,
    input  logic              req_dir,
    input  logic              req_path,
    input  logic [N_MECH-1:0] tt_in_n,
    input  logic [N_MECH-1:0] tt_out_n,
    input  logic              cover_closed_n,
    input  logic              cover_open_n,
    output logic              busy,
    output logic              req_refused,
    output logic [N_MECH-1:0] drv_pri_in,
    output logic [N_MECH-1:0] drv_pri_out,
    output logic [N_MECH-1:0] drv_sec_in,
    output logic [N_MECH-1:0] drv_sec_out,
    output logic              done,
    output logic [1:0]        res_code,
    output logic              cover_closed,
    output logic              cover_open
);

    localparam int SW = 2 * N_MECH + 2;
    localparam int LW = $clog2(PULSE_CYCLES + 1) + 1;

    seq_state_t        state;
    logic [SW-1:0]     synced;
    logic [N_MECH-1:0] s_in_n, s_out_n;
    logic              legal, accept;
    logic [N_MECH-1:0] hot;
    logic              tmr_run, tmr_exp;
    logic [MW-1:0]     sel_mech;
    logic              sel_dir;
    logic              chk_has, chk_val;
    logic              any_drive;

    // Bring all telltales into the clock domain.
    mps_sync #(.W(SW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cover_open_n, cover_closed_n, tt_out_n, tt_in_n}),
        .sync_o  (synced)
    );

    // Split the synchronized bundle and expose cover status active-high.
    always_comb begin
        s_in_n       = synced[N_MECH-1:0];
        s_out_n      = synced[2*N_MECH-1:N_MECH];
        cover_closed = ~synced[2*N_MECH];
        cover_open   = ~synced[2*N_MECH+1];
    end

    // Decide whether the request names a reachable output.
    always_comb begin
        legal = 1'b0;
        hot   = '0;
        for (int i = 0; i < N_MECH; i++) begin
            if (req_mech == MW'(i)) begin
                legal  = !req_path || SEC_PRESENT[i];
                hot[i] = 1'b1;
            end
        end
    end

    always_comb busy   = (state != ST_IDLE);
    always_comb accept = req_valid && !busy && legal;

    // Pulse length source.
    mps_pulse_timer #(.LEN(PULSE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .running (tmr_run),
        .expire  (tmr_exp)
    );

    // Sequencer phase: idle -> pulse -> one check cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept)  state <= ST_RUN;
                ST_RUN:   if (tmr_exp) state <= ST_CHECK;
                ST_CHECK:              state <= ST_IDLE;
                default:               state <= ST_IDLE;
            endcase
        end
    end

    // Latch the target of an accepted move for the later check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mech <= '0;
            sel_dir  <= 1'b0;
        end else if (accept) begin
            sel_mech <= req_mech;
            sel_dir  <= req_dir;
        end
    end

    // Set the one selected drive bit on accept, clear all on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_pri_in  <= '0;
            drv_pri_out <= '0;
            drv_sec_in  <= '0;
            drv_sec_out <= '0;
        end else if (accept) begin
            drv_pri_in  <= ( req_dir && !req_path) ? hot : '0;
            drv_pri_out <= (!req_dir && !req_path) ? hot : '0;
            drv_sec_in  <= ( req_dir &&  req_path) ? hot : '0;
            drv_sec_out <= (!req_dir &&  req_path) ? hot : '0;
        end else if (tmr_exp) begin
            drv_pri_in  <= '0;
            drv_pri_out <= '0;
            drv_sec_in  <= '0;
            drv_sec_out <= '0;
        end
    end

    // Pick the telltale that belongs to the requested position.
    always_comb begin
        chk_has = sel_dir ? IN_TT_PRESENT[sel_mech] : OUT_TT_PRESENT[sel_mech];
        chk_val = sel_dir ? s_in_n[sel_mech]        : s_out_n[sel_mech];
    end

    // Record the outcome in the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            res_code <= RES_NONE;
        end else begin
            done <= (state == ST_CHECK);
            if (state == ST_CHECK) begin
                if (!chk_has)      res_code <= RES_UNVER;
                else if (!chk_val) res_code <= RES_OK;
                else               res_code <= RES_FAIL;
            end
        end
    end

    // Flag every request that was not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) req_refused <= 1'b0;
        else        req_refused <= req_valid && !accept;
    end

    // ---------------- assertions ----------------
    always_comb any_drive = |{drv_pri_in, drv_pri_out, drv_sec_in, drv_sec_out};

    logic [LW-1:0] hi_len;

    // Count consecutive high cycles of any drive output (checker only).
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_len <= '0;
        else if (any_drive) hi_len <= hi_len + 1'b1;
        else                hi_len <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_drive) |-> hi_len == LW'(PULSE_CYCLES)); // R1

    AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drv_pri_in, drv_pri_out, drv_sec_in, drv_sec_out}) <= 1); // R2

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> req_refused); // R3

    AST_SEC_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_sec_in | drv_sec_out) & ~SEC_PRESENT) == '0); // R4

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_drive) |=> (done && !busy)); // R6

endmodule

// File: tb/mech_pulse_seq_tb.sv
// Bench for mech_pulse_seq: behavioural reference model stepped on every
// rising edge, compared with all outputs on every falling edge.
module mech_pulse_seq_tb_top;

    localparam int N   = 3;
    localparam int P   = 20;
    localparam logic [N-1:0] SEC = 3'b011;
    localparam logic [N-1:0] HIN = 3'b011;
    localparam logic [N-1:0] HOUT = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_mech = '0;
    logic req_dir = 1'b0, req_path = 1'b0;
    logic [N-1:0] tt_in_n = '1, tt_out_n = '1;
    logic cover_closed_n = 1'b1, cover_open_n = 1'b1;
    logic busy, req_refused, done, cover_closed, cover_open;
    logic [N-1:0] drv_pri_in, drv_pri_out, drv_sec_in, drv_sec_out;
    logic [1:0] res_code;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    mech_pulse_seq #(
        .N_MECH(N), .PULSE_CYCLES(P), .SEC_PRESENT(SEC),
        .IN_TT_PRESENT(HIN), .OUT_TT_PRESENT(HOUT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mech(req_mech),
        .req_dir(req_dir), .req_path(req_path), .tt_in_n(tt_in_n),
        .tt_out_n(tt_out_n), .cover_closed_n(cover_closed_n),
        .cover_open_n(cover_open_n), .busy(busy), .req_refused(req_refused),
        .drv_pri_in(drv_pri_in), .drv_pri_out(drv_pri_out),
        .drv_sec_in(drv_sec_in), .drv_sec_out(drv_sec_out), .done(done),
        .res_code(res_code), .cover_closed(cover_closed), .cover_open(cover_open)
    );

    // ---------------- reference model ----------------
    int m_phase = 0;      // 0 idle, 1 pulsing, 2 checking
    int m_left = 0;
    int m_mech = 0;
    int m_dir = 0, m_path = 0;
    int m_res = 0;
    bit m_done = 0, m_ref = 0;
    string m_ref_tag = "R3";
    logic [2*N+1:0] m_s1 = '1, m_s2 = '1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_res = 0; m_done = 0; m_ref = 0;
            m_s1 = '1; m_s2 = '1;
        end else begin
            bit lg;
            int has, val;
            m_done = 0;
            m_ref = 0;
            lg = (req_mech < N) && (!req_path || SEC[req_mech]);
            case (m_phase)
                0: if (req_valid) begin
                    if (lg) begin
                        m_phase = 1; m_left = P; m_mech = req_mech;
                        m_dir = req_dir; m_path = req_path;
                    end else begin
                        m_ref = 1; m_ref_tag = "R4";
                    end
                end
                1: begin
                    if (req_valid) begin m_ref = 1; m_ref_tag = "R3"; end
                    m_left--;
                    if (m_left == 0) m_phase = 2;
                end
                default: begin
                    if (req_valid) begin m_ref = 1; m_ref_tag = "R3"; end
                    has = m_dir ? HIN[m_mech] : HOUT[m_mech];
                    val = m_dir ? m_s2[m_mech] : m_s2[N + m_mech];
                    if (!has)     m_res = 3;
                    else if (!val) m_res = 1;
                    else          m_res = 2;
                    m_done = 1;
                    m_phase = 0;
                end
            endcase
            m_s2 = m_s1;
            m_s1 = {cover_open_n, cover_closed_n, tt_out_n, tt_in_n};
        end
    end

    // ---------------- comparison ----------------
    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        logic [N-1:0] e_pi, e_po, e_si, e_so;
        string rtag;
        cycles++;
        e_pi = '0; e_po = '0; e_si = '0; e_so = '0;
        if (m_phase == 1) begin
            if (m_dir == 1 && m_path == 0) e_pi[m_mech] = 1'b1;
            if (m_dir == 0 && m_path == 0) e_po[m_mech] = 1'b1;
            if (m_dir == 1 && m_path == 1) e_si[m_mech] = 1'b1;
            if (m_dir == 0 && m_path == 1) e_so[m_mech] = 1'b1;
        end
        rtag = (m_res == 1) ? "R6" : (m_res == 2) ? "R7" : (m_res == 3) ? "R8" : "R9";
        if (!rst_n) begin
            cmp("R9 reset drives", {drv_pri_in, drv_pri_out, drv_sec_in, drv_sec_out}, 0);
        end else begin
            cmp("R1 drive pri_in", drv_pri_in, e_pi);
            cmp("R1 drive pri_out", drv_pri_out, e_po);
            cmp("R1 drive sec_in", drv_sec_in, e_si);
            cmp("R1 drive sec_out", drv_sec_out, e_so);
            cmp("R2 one drive", int'($countones({drv_pri_in, drv_pri_out, drv_sec_in, drv_sec_out}) <= 1), 1);
            cmp("R3 busy", busy, m_phase != 0);
            cmp({m_ref_tag, " refused"}, req_refused, m_ref);
            cmp("R6 done", done, m_done);
            cmp({rtag, " res_code"}, res_code, m_res);
            cmp("R5 R10 cover_closed", cover_closed, !m_s2[2*N]);
            cmp("R5 R10 cover_open", cover_open, !m_s2[2*N+1]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input int m, input int d, input int p);
        @(negedge clk);
        req_valid = 1'b1; req_mech = 2'(m); req_dir = d[0]; req_path = p[0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        wait_cycles(4);            // R9: reset state compared each cycle
        rst_n = 1'b1;
        wait_cycles(2);

        // R6: slit 0 in, primary, telltale reached
        tt_in_n = 3'b110;
        request(0, 1, 0);
        wait_cycles(5);
        request(1, 0, 0);          // R3: refused during pulse
        wait_idle();

        // R7: slit 1 out, secondary, telltale not reached
        tt_out_n = 3'b111;
        request(1, 0, 1);
        wait_cycles(P - 1);        // request lands in the check cycle: R3
        request(0, 0, 0);
        wait_idle();

        // R8: mirror in has no telltale, even if input is 0
        tt_in_n = 3'b000;
        request(2, 1, 0);
        wait_idle();

        // R6: mirror out primary reached
        tt_out_n = 3'b011;
        request(2, 0, 0);
        wait_idle();

        // R4: mirror secondary and out-of-range index refused
        request(2, 1, 1);
        request(3, 0, 0);
        wait_cycles(2);

        // R5: telltale flips late in the pulse, one and two edges before check
        tt_out_n = 3'b111;
        request(0, 0, 0);
        wait_cycles(P - 2);
        tt_out_n = 3'b110;
        wait_idle();
        tt_out_n = 3'b111;
        request(0, 0, 0);
        wait_cycles(P - 1);
        tt_out_n = 3'b110;
        wait_idle();

        // R10: cover telltales
        cover_closed_n = 1'b0;
        wait_cycles(3);
        cover_open_n = 1'b0; cover_closed_n = 1'b1;
        wait_cycles(3);

        // Sweep all targets with changing telltale patterns (R1 R2)
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 2; p++) begin
                    tt_in_n  = 3'(m * 5 + d * 3 + p);
                    tt_out_n = 3'(m * 3 + p * 5 + d);
                    request(m, d, p);
                    wait_idle();
                end
            end
        end

        // Back-to-back: new request in the cycle after done
        request(1, 1, 0);
        while (!done) @(negedge clk);
        request(1, 0, 0);
        wait_idle();

        wait_cycles(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait_cycles(100_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule